// File: doc/BRIEF.md
# MMC-Anchored Protocol Timer

This block keeps a device's protocol time measured from the start of the most recent MMC preamble, and it also carries the host's channel timestamp forward. Three microsecond counters form a chain. The capture counter starts when the receiver reports PHY activity. When the frame decoder later marks that packet as an MMC, the capture count already equals the time elapsed since the preamble began. That count becomes the protocol time. When the host's timestamp arrives, the channel counter loads it and counts on from it.

All three counters share a clock-enable phase input. `CLKS_PER_US` enabled cycles make one microsecond. A transfer from one counter to the next never adds a residue of a partial microsecond. Instead the transfer is held pending until the source counter sits exactly on a microsecond boundary. The value is then copied with a zero residue. The channel counter is the one exception: its loaded value is raised by one whenever it had to wait across a boundary.

Top module: `mmc_proto_timer`

## Requirements
- R1: After reset, `proto_us` and `chan_us` are 0, and `proto_valid` and `chan_valid` are 0.
- R2: Counters advance only on clock cycles where `phase_en` is 1. `CLKS_PER_US` such cycles make one microsecond. On other cycles every count holds.
- R3: The capture counter restarts from zero on the clock edge where `phy_active` is first seen high. That edge is counted if `phase_en` is 1 on it.
- R4: An `mmc_found` pulse while no capture is running has no effect. `proto_valid` stays 0 and `proto_us` stays 0.
- R5: An `mmc_found` request during a capture takes effect on the first edge, at or after the request, on which the capture residue is zero. From that edge onward, `proto_valid` is 1 and `proto_us` equals the whole microseconds since the capture started.
- R6: `proto_us` wraps modulo 2^`PT_W`.
- R7: If the protocol counter residue is zero when `ts_valid` is seen, the channel counter loads `ts_value` on that edge and counts on from it. `chan_valid` becomes 1.
- R8: If the protocol residue is nonzero when `ts_valid` is seen, the load waits for the next protocol boundary and loads `ts_value`+1. As a result, `chan_us` − `proto_us` stays equal to `ts_value` minus the protocol microseconds at the request.
- R9: `chan_us` wraps modulo 2^`CT_W`.
- R10: A new `phy_active` rise followed by `mmc_found` re-anchors protocol time to the new capture, replacing the running value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_en | input | 1 | Sub-microsecond phase enable |
| phy_active | input | 1 | Receiver busy with a packet |
| mmc_found | input | 1 | Decoder marks the current packet as an MMC (pulse) |
| ts_valid | input | 1 | Channel timestamp present (pulse) |
| ts_value | input | CT_W | Channel timestamp, in microseconds |
| proto_us | output | PT_W | Microseconds since the MMC preamble start |
| proto_valid | output | 1 | Protocol time has been anchored |
| chan_us | output | CT_W | Running channel time, in microseconds |
| chan_valid | output | 1 | Channel time has been loaded |

## Verification
The embedded properties check the following on every cycle:
- each residue stays within its range;
- counts freeze when the phase enable is low;
- the microsecond field steps by one at each residue carry;
- every transfer lands on a zero residue of its source;
- no capture transfer happens while capture is idle.

Some behaviour can only be shown by the bench scenarios:
- the end-to-end result that protocol time equals the microseconds since PHY activity began;
- the +1 correction on a deferred timestamp and the fixed channel-to-protocol offset that follows;
- re-anchoring on a second MMC;
- wrap-around at both widths.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

   function automatic int res_width(input int clks);
      return (clks > 1) ? $clog2(clks) : 1;
   endfunction
endpackage

// File: rtl/mmt_tick_ctr.sv
module mmt_tick_ctr #(
   parameter int CLKS = 8,
   parameter int US_W = 16
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   en,
   input  logic                                   ld,
   input  logic [US_W-1:0]                        ld_us,
   input  logic                                   stop,
   output logic [US_W-1:0]                        us,
   output logic [mmt_pkg::res_width(CLKS)-1:0]    res,
   output logic                                   live
);
   localparam int RES_W = mmt_pkg::res_width(CLKS);
   localparam logic [RES_W-1:0] RES_TOP = RES_W'(CLKS - 1);

   logic [US_W-1:0]  us_q, base_us, us_d;
   logic [RES_W-1:0] res_q, base_res, res_inc, res_d;
   logic             live_q, go, carry;

   always_comb begin
      base_us  = ld ? ld_us : us_q;
      base_res = ld ? '0 : res_q;
      go       = en & (ld | live_q);
   end

   generate
      if (mmt_pkg::is_pow2(CLKS)) begin : g_pow2
         always_comb begin
            carry   = &base_res;
            res_inc = base_res + RES_W'(1);
         end
      end else begin : g_cmp
         always_comb begin
            carry   = (base_res == RES_TOP);
            res_inc = carry ? '0 : base_res + RES_W'(1);
         end
      end
   endgenerate

   always_comb begin
      res_d = go ? res_inc : base_res;
      us_d  = (go && carry) ? base_us + US_W'(1) : base_us;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         us_q   <= '0;
         res_q  <= '0;
         live_q <= 1'b0;
      end else begin
         us_q   <= us_d;
         res_q  <= res_d;
         live_q <= ld ? 1'b1 : (stop ? 1'b0 : live_q);
      end
   end

   assign us   = us_q;
   assign res  = res_q;
   assign live = live_q;

   AST_RES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_q <= RES_TOP); // R2
   AST_HOLD_NO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ld) |=> ($stable(us_q) && $stable(res_q))); // R2
   AST_US_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && live_q && !ld && res_q == RES_TOP) |=>
      (us_q == $past(us_q) + US_W'(1) && res_q == '0)); // R6
endmodule

// File: rtl/mmt_hand_gate.sv
module mmt_hand_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic ok,
   input  logic clr,
   input  logic src_edge,
   output logic fire,
   output logic waited
);
   logic pend_q;

   assign fire   = ok & ~clr & src_edge & (req | pend_q);
   assign waited = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pend_q <= 1'b0;
      else if (clr || !ok)      pend_q <= 1'b0;
      else if (fire)            pend_q <= 1'b0;
      else if (req)             pend_q <= 1'b1;
   end

   AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && ok && !clr && src_edge) |=> !pend_q); // R5
endmodule

// File: rtl/mmc_proto_timer.sv
module mmc_proto_timer #(
   parameter int CLKS_PER_US = 8,
   parameter int PT_W        = 16,
   parameter int CT_W        = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            phase_en,
   input  logic            phy_active,
   input  logic            mmc_found,
   input  logic            ts_valid,
   input  logic [CT_W-1:0] ts_value,
   output logic [PT_W-1:0] proto_us,
   output logic            proto_valid,
   output logic [CT_W-1:0] chan_us,
   output logic            chan_valid
);
   localparam int RES_W = mmt_pkg::res_width(CLKS_PER_US);

   generate
      if (CLKS_PER_US < 2) begin : g_bad_clks
         $error("CLKS_PER_US must be at least 2");
      end
      if (PT_W < 4 || CT_W < 4) begin : g_bad_width
         $error("PT_W and CT_W must be at least 4");
      end
   endgenerate

   logic             phy_q, phy_rise;
   logic [PT_W-1:0]  a_us, b_us;
   logic [RES_W-1:0] a_res, b_res, c_res;
   logic             a_live, b_live, c_live;
   logic             fire_ab, fire_bc, ab_wait, bc_wait;
   logic [CT_W-1:0]  ts_hold, c_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phy_q   <= 1'b0;
         ts_hold <= '0;
      end else begin
         phy_q <= phy_active;
         if (ts_valid) ts_hold <= ts_value;
      end
   end

   assign phy_rise = phy_active & ~phy_q;

   mmt_tick_ctr #(.CLKS(CLKS_PER_US), .US_W(PT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .en(phase_en), .ld(phy_rise), .ld_us('0),
      .stop(fire_ab), .us(a_us), .res(a_res), .live(a_live));

   mmt_hand_gate u_gate_ab (
      .clk(clk), .rst_n(rst_n), .req(mmc_found), .ok(a_live), .clr(phy_rise),
      .src_edge(a_res == '0), .fire(fire_ab), .waited(ab_wait));

   mmt_tick_ctr #(.CLKS(CLKS_PER_US), .US_W(PT_W)) u_proto (
      .clk(clk), .rst_n(rst_n), .en(phase_en), .ld(fire_ab), .ld_us(a_us),
      .stop(1'b0), .us(b_us), .res(b_res), .live(b_live));

   mmt_hand_gate u_gate_bc (
      .clk(clk), .rst_n(rst_n), .req(ts_valid), .ok(1'b1), .clr(1'b0),
      .src_edge(b_res == '0), .fire(fire_bc), .waited(bc_wait));

   // a fresh request is aligned now; a deferred one crossed one boundary
   assign c_ld = ts_valid ? ts_value : ts_hold + CT_W'(1);

   mmt_tick_ctr #(.CLKS(CLKS_PER_US), .US_W(CT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .en(phase_en), .ld(fire_bc), .ld_us(c_ld),
      .stop(1'b0), .us(chan_us), .res(c_res), .live(c_live));

   assign proto_us    = b_us;
   assign proto_valid = b_live;
   assign chan_valid  = c_live;

   AST_IDLE_MMC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !a_live |-> !fire_ab); // R4
   AST_CAP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      fire_ab |-> (a_res == '0)); // R5
   AST_WAIT_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ab_wait |-> a_live); // R5
   AST_CHAN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      fire_bc |-> (b_res == '0)); // R8
   AST_CHAN_DEFER_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_bc && bc_wait && !ts_valid) |-> (c_ld == ts_hold + CT_W'(1))); // R8
   AST_CHAN_LOAD_RES: assert property (@(posedge clk) disable iff (!rst_n)
      fire_bc |=> (c_res == ($past(phase_en) ? RES_W'(1) : RES_W'(0)))); // R7
endmodule

// File: tb/sim_mmc_proto_timer.sv
module sim_mmc_proto_timer;
   localparam int CLKS = 8;
   localparam int PTW  = 8;
   localparam int CTW  = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           phase_en = 1'b1;
   logic           phy_active = 1'b0;
   logic           mmc_found = 1'b0;
   logic           ts_valid = 1'b0;
   logic [CTW-1:0] ts_value = '0;
   logic [PTW-1:0] proto_us;
   logic           proto_valid;
   logic [CTW-1:0] chan_us;
   logic           chan_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   mmc_proto_timer #(.CLKS_PER_US(CLKS), .PT_W(PTW), .CT_W(CTW)) u0 (
      .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .phy_active(phy_active),
      .mmc_found(mmc_found), .ts_valid(ts_valid), .ts_value(ts_value),
      .proto_us(proto_us), .proto_valid(proto_valid),
      .chan_us(chan_us), .chan_valid(chan_valid));

   // columns: edges before mmc, edges after mmc, expected proto_us, expected proto_valid
   localparam int NV = 6;
   localparam int VEC [NV][4] = '{
      '{8, 0, 1, 1}, '{8, 20, 3, 1}, '{3, 2, 0, 0},
      '{3, 5, 1, 1}, '{13, 30, 5, 1}, '{1, 100, 12, 1}};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; phase_en = 1'b1; phy_active = 1'b0;
      mmc_found = 1'b0; ts_valid = 1'b0; ts_value = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic capture(input int pre, input int post);
      phy_active = 1'b1;
      edges(pre);
      mmc_found = 1'b1;
      edges(1);
      mmc_found = 1'b0;
      edges(post);
   endtask

   initial begin
      do_reset();
      chk("R1 proto_us", 32'(proto_us), 0);
      chk("R1 chan_us", 32'(chan_us), 0);
      chk("R1 proto_valid", 32'(proto_valid), 0);
      chk("R1 chan_valid", 32'(chan_valid), 0);

      // R3 R5: anchoring under several request offsets
      for (int i = 0; i < NV; i++) begin
         do_reset();
         capture(VEC[i][0], VEC[i][1]);
         chk("R5 proto_us", 32'(proto_us), 32'(VEC[i][2]));
         chk("R5 proto_valid", 32'(proto_valid), 32'(VEC[i][3]));
      end

      // R4: mmc_found with no capture running
      do_reset();
      mmc_found = 1'b1; edges(1); mmc_found = 1'b0; edges(20);
      chk("R4 proto_valid", 32'(proto_valid), 0);
      chk("R4 proto_us", 32'(proto_us), 0);

      // R2: phase enable on alternate edges, 30 enabled of 60
      do_reset();
      phy_active = 1'b1;
      for (int i = 0; i < 60; i++) begin
         phase_en  = (i % 2 == 0);
         mmc_found = (i == 2);
         @(negedge clk);
      end
      mmc_found = 1'b0;
      phase_en = 1'b0;
      chk("R2 proto_us", 32'(proto_us), 3);
      edges(5);
      chk("R2 hold without phase", 32'(proto_us), 3);
      phase_en = 1'b1;

      // R6: wrap, 258 us with an 8-bit field
      do_reset();
      capture(8, 2056);
      chk("R6 proto_us wrap", 32'(proto_us), 2);

      // R7: aligned timestamp (protocol counter idle, residue zero)
      do_reset();
      ts_value = 16'd1000; ts_valid = 1'b1; edges(1); ts_valid = 1'b0;
      edges(15);
      chk("R7 chan_valid", 32'(chan_valid), 1);
      chk("R7 chan_us", 32'(chan_us), 1002);

      // R9: channel wrap
      do_reset();
      ts_value = 16'hFFFF; ts_valid = 1'b1; edges(1); ts_valid = 1'b0;
      edges(15);
      chk("R9 chan_us wrap", 32'(chan_us), 1);

      // R8: timestamp at protocol residue 3, deferred to the next boundary
      do_reset();
      phy_active = 1'b1;
      edges(8);
      mmc_found = 1'b1; edges(1); mmc_found = 1'b0;  // edge 8
      edges(2);                                        // edges 9,10
      ts_value = 16'd500; ts_valid = 1'b1; edges(1); ts_valid = 1'b0; // edge 11
      edges(3);                                        // to E=15
      chk("R8 still pending", 32'(chan_valid), 0);
      edges(2);                                        // E=17
      chk("R8 chan_valid", 32'(chan_valid), 1);
      chk("R8 chan_us at load", 32'(chan_us), 501);
      edges(23);                                       // E=40
      chk("R8 proto_us", 32'(proto_us), 5);
      chk("R8 chan_us offset", 32'(chan_us), 504);

      // R10: a second capture re-anchors protocol time
      do_reset();
      capture(8, 31);
      chk("R10 first anchor", 32'(proto_us), 5);
      phy_active = 1'b0; edges(1);
      capture(8, 8);
      chk("R10 re-anchor", 32'(proto_us), 2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule